// File: doc/BRIEF.md
# Infrared Serial Pulse Encoder/Decoder

This block sits between a UART and an infrared transceiver. On the transmit side it takes the UART's NRZ output and the UART's 16x baud tick. It turns every zero bit into a short high pulse on the infrared output. A one bit leaves the output low. On the receive side it watches the infrared input. It filters out glitches, and for each valid pulse it rebuilds an NRZ low bit for the UART receiver. At all other times that line idles high.

There are two pulse shapes. In normal mode the pulse covers three of the sixteen ticks in the middle of the bit. In low-power mode the pulse lasts exactly three periods of a separate low-power reference. That reference is the system clock divided by a programmable divisor held in the block. The link is half-duplex: while the block is sending a zero bit, the infrared input is ignored.

Top module: `sir_codec`

## Requirements
- R1: Out of reset, `ir_out` is low, `rx_nrz` is high and the low-power divisor is 0.
- R2: In normal mode (`lp_mode`=0), a zero bit drives `ir_out` high for exactly 3 tick periods. The pulse starts one clock after the tick that begins sixteenth 7 of the bit.
- R3: A one bit produces no pulse on `ir_out` in either mode.
- R4: In low-power mode (`lp_mode`=1) with divisor D>0, a zero bit drives `ir_out` high for exactly 3*D clocks. It starts at the same point as in R2.
- R5: A clock with `lpdiv_we`=1 loads `lpdiv_wdata` into the divisor. A divisor of 0 in low-power mode suppresses every pulse.
- R6: A valid pulse on `ir_in` drives `rx_nrz` low until 16 `baud_tick16` ticks have passed after detection. That low time lies between 15 and 16 tick periods.
- R7: Glitch filter. A pulse on `ir_in` counts as valid only when it stays high for at least D consecutive clocks, or 1 clock when D=0. Shorter pulses leave `rx_nrz` high.
- R8: While the bit currently being sent is a zero, `ir_in` is ignored and `rx_nrz` stays high.
- R9: Sixteenths are counted by `baud_tick16` from reset. The first tick after reset starts a bit, and `tx_nrz` is sampled on that tick and on every sixteenth tick after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick16 | input | 1 | One-clock pulse at 16x the baud rate |
| tx_nrz | input | 1 | NRZ transmit line from the UART |
| lp_mode | input | 1 | 1 selects low-power pulse width |
| lpdiv_we | input | 1 | Write strobe for the low-power divisor |
| lpdiv_wdata | input | DIV_W | New low-power divisor value |
| ir_in | input | 1 | Infrared receive pulse input (asynchronous) |
| ir_out | output | 1 | Infrared transmit pulse output |
| rx_nrz | output | 1 | Rebuilt NRZ receive line to the UART |

## Verification
The assertions assume the UART changes `tx_nrz` only at bit boundaries as counted by this block. They also assume `lp_mode` and the divisor are rewritten only while no pulse is in flight, and that `baud_tick16` is never high on consecutive clocks. The stimulus meets these rules. Every bit is driven only after the bench's own tick counter reaches sixteenth 15. Mode and divisor changes happen between complete bit sequences. The bench's tick generator fires once every four clocks.

// File: rtl/sir_pkg.sv
// Shared constants for the infrared pulse codec.
// Assumes a 16x oversampling tick from the UART baud generator.
package sir_pkg;
    localparam int unsigned TICKS_PER_BIT = 16;
    localparam int unsigned PH_W          = $clog2(TICKS_PER_BIT);
    localparam int unsigned PULSE_FIRST   = 7;   // first sixteenth of the normal pulse
    localparam int unsigned PULSE_LAST    = 9;   // last sixteenth of the normal pulse
    localparam int unsigned LP_PERIODS    = 3;   // low-power pulse length in reference periods
    localparam int unsigned RXC_W         = $clog2(TICKS_PER_BIT + 1);
    typedef logic [PH_W-1:0] phase_t;
endpackage

// File: rtl/sir_lp_div.sv
// Low-power reference divider. Holds the programmable divisor and emits a
// one-clock tick every D clocks. The phase is realigned by restart.
// Assumes D=0 means disabled: no ticks are produced.
module sir_lp_div #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [DIV_W-1:0] wdata,
    input  logic             restart,
    output logic [DIV_W-1:0] div_q,
    output logic             lp_tick
);
    logic [DIV_W-1:0] cnt;

    assign lp_tick = (div_q != '0) && (cnt == div_q - DIV_W'(1));

    // Divisor register and period counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (wr) begin
            div_q <= wdata;
            cnt   <= '0;
        end else if (restart || div_q == '0 || lp_tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    assert_div_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q != '0) |-> (cnt < div_q));
endmodule

// File: rtl/sir_encoder.sv
// Transmit side: counts sixteenths, latches the UART bit at each bit start,
// and shapes zero bits into a mid-bit pulse (normal) or a 3-reference-period
// pulse (low power). Assumes tx_nrz changes only at bit boundaries.
module sir_encoder
    import sir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    input  logic tx_nrz,
    input  logic lp_mode,
    input  logic lp_en,
    input  logic lp_tick,
    output logic lp_restart,
    output logic tx_bit,
    output logic ir_out
);
    phase_t     ph;
    logic       bit_q;
    logic       lp_active;
    logic [1:0] lp_cnt;
    logic       mid_window;

    assign tx_bit     = bit_q;
    assign mid_window = (ph >= phase_t'(PULSE_FIRST)) && (ph <= phase_t'(PULSE_LAST));
    assign lp_restart = tick16 && (ph == phase_t'(PULSE_FIRST - 1)) && !bit_q && lp_mode && lp_en;

    // Sixteenth counter and bit latch; first tick after reset starts a bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= '1;
            bit_q <= 1'b1;
        end else if (tick16) begin
            ph <= ph + phase_t'(1);
            if (ph == phase_t'(TICKS_PER_BIT - 1)) bit_q <= tx_nrz;
        end
    end

    // Low-power pulse timer, counting reference periods
    always_ff @(posedge clk) begin
        if (!rst_n || !lp_en) begin
            lp_active <= 1'b0;
            lp_cnt    <= '0;
        end else if (lp_restart) begin
            lp_active <= 1'b1;
            lp_cnt    <= '0;
        end else if (lp_active && lp_tick) begin
            if (lp_cnt == 2'(LP_PERIODS - 1)) lp_active <= 1'b0;
            else                              lp_cnt    <= lp_cnt + 2'd1;
        end
    end

    // Registered output selection
    always_ff @(posedge clk) begin
        if (!rst_n) ir_out <= 1'b0;
        else        ir_out <= lp_mode ? lp_active : (!bit_q && mid_window);
    end

    assert_normal_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_mode && $past(!lp_mode) && $rose(ir_out)) |-> (ph == phase_t'(PULSE_FIRST)));
    assert_one_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_mode && $past(!lp_mode) && bit_q && $past(bit_q)) |-> !ir_out);
    assert_lp_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_en && $past(!lp_en)) |-> !lp_active);
endmodule

// File: rtl/sir_decoder.sv
// Receive side: synchronises the infrared input, accepts a pulse once it has
// stayed high for the glitch threshold, then holds rx low for 16 ticks.
// Assumes "blocked" is high while a zero bit is being sent (half-duplex).
module sir_decoder
    import sir_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             ir_in,
    input  logic             blocked,
    input  logic [DIV_W-1:0] div_q,
    output logic             rx_nrz
);
    logic             s1, s2;
    logic [DIV_W-1:0] hi_cnt;
    logic [DIV_W-1:0] thr;
    logic             armed;
    logic             detect;
    logic [RXC_W-1:0] rx_cnt;

    assign thr    = (div_q == '0) ? DIV_W'(1) : div_q;
    assign detect = s2 && !blocked && armed && (hi_cnt == thr - DIV_W'(1));
    assign rx_nrz = (rx_cnt == '0);

    // Two-stage input synchroniser
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= ir_in;
            s2 <= s1;
        end
    end

    // Glitch filter: count consecutive high samples, fire once per pulse
    always_ff @(posedge clk) begin
        if (!rst_n || !s2 || blocked) begin
            hi_cnt <= '0;
            armed  <= 1'b1;
        end else if (detect) begin
            armed <= 1'b0;
        end else if (armed) begin
            hi_cnt <= hi_cnt + DIV_W'(1);
        end
    end

    // Rebuilt bit length counter
    always_ff @(posedge clk) begin
        if (!rst_n)                       rx_cnt <= '0;
        else if (detect)                  rx_cnt <= RXC_W'(TICKS_PER_BIT);
        else if (tick16 && rx_cnt != '0)  rx_cnt <= rx_cnt - RXC_W'(1);
    end

    assert_rx_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= RXC_W'(TICKS_PER_BIT));
    assert_halfdup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_nrz) |-> $past(!blocked));
endmodule

// File: rtl/sir_codec.sv
// Top: infrared pulse codec between a UART and an optical transceiver.
// Assumes baud_tick16 is a single-clock pulse and tx_nrz follows its bits.
module sir_codec #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick16,
    input  logic             tx_nrz,
    input  logic             lp_mode,
    input  logic             lpdiv_we,
    input  logic [DIV_W-1:0] lpdiv_wdata,
    input  logic             ir_in,
    output logic             ir_out,
    output logic             rx_nrz
);
    logic [DIV_W-1:0] div_q;
    logic             lp_tick;
    logic             lp_restart;
    logic             tx_bit;

    sir_lp_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .wr(lpdiv_we), .wdata(lpdiv_wdata),
        .restart(lp_restart), .div_q(div_q), .lp_tick(lp_tick)
    );

    sir_encoder u_enc (
        .clk(clk), .rst_n(rst_n), .tick16(baud_tick16), .tx_nrz(tx_nrz),
        .lp_mode(lp_mode), .lp_en(div_q != '0), .lp_tick(lp_tick),
        .lp_restart(lp_restart), .tx_bit(tx_bit), .ir_out(ir_out)
    );

    sir_decoder #(.DIV_W(DIV_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .tick16(baud_tick16), .ir_in(ir_in),
        .blocked(!tx_bit), .div_q(div_q), .rx_nrz(rx_nrz)
    );

    assert_reset_R1: assert property (@(posedge clk) $past(!rst_n) |-> (!ir_out && rx_nrz));
endmodule

// File: tb/sim_sir_codec.sv
module sim_sir_codec;
    localparam int TP = 4;   // clocks per tick16

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick16 = 1'b0;
    logic       tx_nrz = 1'b1;
    logic       lp_mode = 1'b0;
    logic       lpdiv_we = 1'b0;
    logic [7:0] lpdiv_wdata = '0;
    logic       ir_in = 1'b0;
    logic       ir_out, rx_nrz;

    int n_checks = 0, n_fail = 0;
    int tick_n = 0, tdiv = 0;
    int exp_ir[$];
    int exp_rx[$];
    int ir_seen = 0, rx_seen = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    sir_codec u0 (.clk(clk), .rst_n(rst_n), .baud_tick16(baud_tick16), .tx_nrz(tx_nrz),
                  .lp_mode(lp_mode), .lpdiv_we(lpdiv_we), .lpdiv_wdata(lpdiv_wdata),
                  .ir_in(ir_in), .ir_out(ir_out), .rx_nrz(rx_nrz));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // tick generator: one pulse every TP clocks after reset
    always @(negedge clk) begin
        if (!rst_n) begin tdiv <= 0; baud_tick16 <= 1'b0; end
        else begin
            tdiv <= (tdiv == TP-1) ? 0 : tdiv + 1;
            baud_tick16 <= (tdiv == TP-1);
        end
    end
    always @(posedge clk) if (!rst_n) tick_n <= 0; else if (baud_tick16) tick_n <= tick_n + 1;

    task automatic wait_tick();
        do @(posedge clk); while (baud_tick16 !== 1'b1);
    endtask

    // wait until the bench phase reaches sixteenth 15 (next tick starts a bit)
    task automatic align();
        do @(negedge clk); while (!(tick_n == 0 || (tick_n-1) % 16 == 15));
    endtask

    task automatic send_bit(input bit b);
        align();
        tx_nrz = b;
        if (!b) exp_ir.push_back(lp_mode ? 3*int'(lpdiv_wdata) : 3*TP);
        repeat (16) wait_tick();
    endtask

    task automatic wr_div(input logic [7:0] v);
        @(negedge clk); lpdiv_we = 1'b1; lpdiv_wdata = v;
        @(negedge clk); lpdiv_we = 1'b0;
    endtask

    task automatic pulse_ir(input int n);
        @(negedge clk); ir_in = 1'b1;
        repeat (n) @(negedge clk);
        ir_in = 1'b0;
    endtask

    // monitor: infrared output pulses against the scoreboard
    int ir_w = 0;
    logic ir_prev = 1'b0;
    always @(negedge clk) if (rst_n) begin
        if (ir_out) begin
            if (!ir_prev) begin
                ir_w = 1;
                check((tick_n-1) % 16 == 7, "R9 pulse start sixteenth", (tick_n-1) % 16, 7);
            end else ir_w++;
        end else if (ir_prev) begin
            ir_seen++;
            if (exp_ir.size() == 0) check(0, "R3 unexpected ir pulse", ir_w, 0);
            else begin
                automatic int e = exp_ir.pop_front();
                check(ir_w == e, lp_mode ? "R4 low-power width" : "R2 normal width", ir_w, e);
            end
        end
        ir_prev = ir_out;
    end

    // monitor: rebuilt rx low bits against the scoreboard
    int rx_w = 0;
    logic rx_prev = 1'b1;
    always @(negedge clk) if (rst_n) begin
        if (!rx_nrz) rx_w = rx_prev ? 1 : rx_w + 1;
        else if (!rx_prev) begin
            rx_seen++;
            if (exp_rx.size() == 0) check(0, "R7/R8 unexpected rx bit", rx_w, 0);
            else begin
                automatic int e = exp_rx.pop_front();
                check(rx_w > (e-1)*TP && rx_w <= e*TP, "R6 rx low width", rx_w, e*TP);
            end
        end
        rx_prev = rx_nrz;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seen;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ir_out == 1'b0, "R1 ir_out reset", ir_out, 0);
        check(rx_nrz == 1'b1, "R1 rx_nrz reset", rx_nrz, 1);
        rst_n = 1'b1;

        // normal mode, divisor 0 (R1 divisor reset value also exercised by R7 threshold)
        send_bit(0); send_bit(1); send_bit(0); send_bit(0);
        seen = ir_seen;
        send_bit(1); send_bit(1);
        check(ir_seen == seen, "R3 one bits quiet", ir_seen - seen, 0);

        // low-power mode with divisor 0: suppressed
        lp_mode = 1'b1;
        seen = ir_seen;
        align(); tx_nrz = 1'b0; repeat (16) wait_tick();
        send_bit(1); send_bit(1);
        check(ir_seen == seen, "R5 divisor 0 suppresses", ir_seen - seen, 0);

        // low-power mode with divisor 5
        wr_div(8'd5);
        send_bit(0); send_bit(1); send_bit(0); send_bit(1); send_bit(1);

        // decoder, divisor 5, line idle high
        exp_rx.push_back(16); pulse_ir(8); repeat (20) wait_tick();
        seen = rx_seen;
        pulse_ir(3); repeat (20) wait_tick();
        pulse_ir(4); repeat (20) wait_tick();
        check(rx_seen == seen, "R7 short pulses rejected", rx_seen - seen, 0);
        exp_rx.push_back(16); pulse_ir(5); repeat (20) wait_tick();
        check(rx_seen == seen + 1, "R7 threshold pulse accepted", rx_seen - seen, 1);

        // divisor 0: one clock is enough
        wr_div(8'd0); lp_mode = 1'b0;
        exp_rx.push_back(16); pulse_ir(1); repeat (20) wait_tick();

        // half-duplex: input ignored while sending a zero
        seen = rx_seen;
        align();
        exp_ir.push_back(3*TP);
        tx_nrz = 1'b0;
        fork
            repeat (16) wait_tick();
            begin repeat (2) wait_tick(); pulse_ir(10); end
        join
        send_bit(1); send_bit(1);
        check(rx_seen == seen, "R8 rx ignored while sending", rx_seen - seen, 0);
        check(rx_nrz == 1'b1, "R8 rx idle", rx_nrz, 1);

        check(exp_ir.size() == 0, "R2/R4 all ir pulses seen", exp_ir.size(), 0);
        check(exp_rx.size() == 0, "R6 all rx bits seen", exp_rx.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule